// File: doc/BRIEF.md
# CAN Identifier Acceptance Filter

This block decides whether a received CAN frame should go into the receive storage. It compares the frame's 32-bit identifier word against a small bank of programmable mask and identifier pairs. Software loads each pair through a simple write port and switches filters on or off through an enable word. Every identifier presented with a valid strobe gets an accept or reject answer on the next cycle.

A filter matches when the bits selected by its mask are equal in the incoming word and in the stored identifier. A frame is accepted when any enabled filter matches it. When no filter is enabled at all, every frame is accepted.

A filter's mask and identifier can only be rewritten while that filter is disabled and no decision is in flight. A write that breaks this rule is dropped without any effect. The identifier word holds standard and extended frames in one layout:

- bits 31..21: base identifier
- bit 20: substitute remote request
- bit 19: extension flag
- bits 18..1: extended identifier
- bit 0: remote request

Top module: `can_id_acceptance`

## Requirements
- R1: A synchronous active-high reset clears all mask and identifier registers to zero, disables every filter, and drives `dec_valid`, `dec_accept` and `busy` low.
- R2: Filter i matches an identifier word X when (X & mask_i) == (ident_i & mask_i) over all 32 bits. A zero mask bit makes that bit position a don't-care.
- R3: When at least one filter is enabled, `dec_accept` is 1 exactly when one or more enabled filters match. A matching filter whose enable bit is 0 has no effect.
- R4: When the enable word is all zero, every presented identifier is accepted.
- R5: An identifier sampled with `id_valid` high produces `dec_valid` high for one cycle, on the next cycle, with `dec_accept` valid in that cycle. `busy` is high in that same cycle.
- R6: A write to the mask or identifier register of a filter whose enable bit is 1 is ignored.
- R7: A write to any mask or identifier register in a cycle where `busy` is high is ignored.
- R8: The identifier layout places the extension flag at bit 19 and the remote request at bit 0. A filter with mask 0x0008_0000 and identifier 0x0008_0000 therefore accepts exactly the extended frames.
- R9: `rd_data` returns the register picked by `rd_sel` and `rd_mask` (1 = mask, 0 = identifier) one cycle after the selection. `en_state` shows the enable word directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| id_valid | input | 1 | Identifier word present this cycle |
| id_word | input | 32 | Received identifier word |
| wr_en | input | 1 | Write strobe for a mask or identifier register |
| wr_sel | input | 2 | Filter index for the write |
| wr_mask | input | 1 | 1 writes the mask, 0 writes the identifier |
| wr_data | input | 32 | Write data |
| en_wr | input | 1 | Load the enable word |
| en_data | input | 4 | New enable word, one bit per filter |
| rd_sel | input | 2 | Filter index for readback |
| rd_mask | input | 1 | 1 reads the mask, 0 reads the identifier |
| rd_data | output | 32 | Registered readback data |
| en_state | output | 4 | Current enable word |
| dec_valid | output | 1 | One-cycle decision strobe |
| dec_accept | output | 1 | Decision: 1 accept, 0 reject |
| busy | output | 1 | Decision in flight; filter writes are locked |

## Verification
A corrupted mask or identifier bit changes `dec_accept` for some identifier. That change appears one cycle after the identifier is presented. A wrong enable or fallback decision shows up the same way across the sweep of all sixteen enable words. A write lock that leaks shows in `rd_data` one cycle after the register is selected.

// File: rtl/can_acf_pkg.sv
package can_acf_pkg;
  localparam int ACF_ID_W = 32;
  localparam int ACF_NUM  = 4;
  localparam int ACF_SEL_W = (ACF_NUM > 1) ? $clog2(ACF_NUM) : 1;
endpackage

// File: rtl/acf_regbank.sv
module acf_regbank #(
  parameter int ID_W  = 32,
  parameter int NUM   = 4,
  parameter int SEL_W = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_en,
  input  logic [SEL_W-1:0]          wr_sel,
  input  logic                      wr_mask,
  input  logic [ID_W-1:0]           wr_data,
  input  logic                      en_wr,
  input  logic [NUM-1:0]            en_data,
  input  logic                      busy,
  output logic [NUM-1:0]            en_q,
  output logic [NUM-1:0][ID_W-1:0]  masks,
  output logic [NUM-1:0][ID_W-1:0]  idents
);
  always_ff @(posedge clk) begin
    if (rst)        en_q <= '0;
    else if (en_wr) en_q <= en_data;
  end

  for (genvar i = 0; i < NUM; i++) begin : g_slot
    logic            slot_wr;
    logic [ID_W-1:0] m_r;
    logic [ID_W-1:0] f_r;
    assign slot_wr = wr_en && (wr_sel == SEL_W'(i)) && !en_q[i] && !busy;
    always_ff @(posedge clk) begin
      if (rst) begin
        m_r <= '0;
        f_r <= '0;
      end else if (slot_wr) begin
        if (wr_mask) m_r <= wr_data;
        else         f_r <= wr_data;
      end
    end
    assign masks[i]  = m_r;
    assign idents[i] = f_r;
  end
endmodule

// File: rtl/acf_entry.sv
module acf_entry #(
  parameter int ID_W = 32
) (
  input  logic [ID_W-1:0] id_word,
  input  logic [ID_W-1:0] mask,
  input  logic [ID_W-1:0] ident,
  output logic            hit
);
  assign hit = ((id_word ^ ident) & mask) == '0;
endmodule

// File: rtl/acf_decide.sv
module acf_decide #(
  parameter int NUM = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           id_valid,
  input  logic [NUM-1:0] hits,
  input  logic [NUM-1:0] en_q,
  output logic           dec_valid,
  output logic           dec_accept,
  output logic           busy
);
  logic verdict;
  assign verdict = (en_q == '0) ? 1'b1 : |(hits & en_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      dec_valid  <= 1'b0;
      dec_accept <= 1'b0;
      busy       <= 1'b0;
    end else begin
      dec_valid <= id_valid;
      busy      <= id_valid;
      if (id_valid) dec_accept <= verdict;
    end
  end
endmodule

// File: rtl/can_id_acceptance.sv
module can_id_acceptance
  import can_acf_pkg::*;
#(
  parameter int ID_W  = ACF_ID_W,
  parameter int NUM   = ACF_NUM,
  parameter int SEL_W = ACF_SEL_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             id_valid,
  input  logic [ID_W-1:0]  id_word,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic             wr_mask,
  input  logic [ID_W-1:0]  wr_data,
  input  logic             en_wr,
  input  logic [NUM-1:0]   en_data,
  input  logic [SEL_W-1:0] rd_sel,
  input  logic             rd_mask,
  output logic [ID_W-1:0]  rd_data,
  output logic [NUM-1:0]   en_state,
  output logic             dec_valid,
  output logic             dec_accept,
  output logic             busy
);
  logic [NUM-1:0]           en_q;
  logic [NUM-1:0][ID_W-1:0] masks;
  logic [NUM-1:0][ID_W-1:0] idents;
  logic [NUM-1:0]           hits;

  acf_regbank #(.ID_W(ID_W), .NUM(NUM), .SEL_W(SEL_W)) u_bank (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_mask(wr_mask),
    .wr_data(wr_data), .en_wr(en_wr), .en_data(en_data), .busy(busy),
    .en_q(en_q), .masks(masks), .idents(idents)
  );

  for (genvar i = 0; i < NUM; i++) begin : g_cmp
    acf_entry #(.ID_W(ID_W)) u_entry (
      .id_word(id_word), .mask(masks[i]), .ident(idents[i]), .hit(hits[i])
    );
  end

  acf_decide #(.NUM(NUM)) u_dec (
    .clk(clk), .rst(rst), .id_valid(id_valid), .hits(hits), .en_q(en_q),
    .dec_valid(dec_valid), .dec_accept(dec_accept), .busy(busy)
  );

  always_ff @(posedge clk) begin
    if (rst)          rd_data <= '0;
    else if (rd_mask) rd_data <= masks[rd_sel];
    else              rd_data <= idents[rd_sel];
  end

  assign en_state = en_q;
endmodule

// File: rtl/acf_chk.sv
module acf_chk #(
  parameter int ID_W  = 32,
  parameter int NUM   = 4,
  parameter int SEL_W = 2
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     id_valid,
  input logic                     wr_en,
  input logic [SEL_W-1:0]         wr_sel,
  input logic [NUM-1:0]           en_q,
  input logic [NUM-1:0][ID_W-1:0] masks,
  input logic [NUM-1:0][ID_W-1:0] idents,
  input logic                     dec_valid,
  input logic                     dec_accept,
  input logic                     busy
);
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (en_q == '0) && !dec_valid && !busy && !dec_accept);

  a_r5_strobe_follows: assert property (@(posedge clk) disable iff (rst)
    id_valid |=> dec_valid && busy);

  a_r5_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !id_valid |=> !dec_valid && !busy);

  a_r4_fallback_accept: assert property (@(posedge clk) disable iff (rst)
    (id_valid && en_q == '0) |=> dec_accept);

  a_r6_enabled_locked: assert property (@(posedge clk) disable iff (rst)
    (wr_en && en_q[wr_sel]) |=> ($stable(masks) && $stable(idents)));

  a_r7_busy_locked: assert property (@(posedge clk) disable iff (rst)
    (wr_en && busy) |=> ($stable(masks) && $stable(idents)));
endmodule

bind can_id_acceptance acf_chk #(.ID_W(ID_W), .NUM(NUM), .SEL_W(SEL_W)) u_chk (
  .clk(clk), .rst(rst), .id_valid(id_valid), .wr_en(wr_en), .wr_sel(wr_sel),
  .en_q(en_q), .masks(masks), .idents(idents), .dec_valid(dec_valid),
  .dec_accept(dec_accept), .busy(busy)
);

// File: tb/tb_can_id_acceptance.sv
`timescale 1ns/1ps
module tb_can_id_acceptance;
  logic        clk = 1'b0;
  logic        rst;
  logic        id_valid;
  logic [31:0] id_word;
  logic        wr_en;
  logic [1:0]  wr_sel;
  logic        wr_mask;
  logic [31:0] wr_data;
  logic        en_wr;
  logic [3:0]  en_data;
  logic [1:0]  rd_sel;
  logic        rd_mask;
  logic [31:0] rd_data;
  logic [3:0]  en_state;
  logic        dec_valid;
  logic        dec_accept;
  logic        busy;

  int checks = 0;
  int errors = 0;
  logic [31:0] m_ref [4];
  logic [31:0] f_ref [4];

  always #5 clk = ~clk;

  can_id_acceptance dut (
    .clk(clk), .rst(rst), .id_valid(id_valid), .id_word(id_word),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_mask(wr_mask), .wr_data(wr_data),
    .en_wr(en_wr), .en_data(en_data), .rd_sel(rd_sel), .rd_mask(rd_mask),
    .rd_data(rd_data), .en_state(en_state), .dec_valid(dec_valid),
    .dec_accept(dec_accept), .busy(busy)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put_reg(input int sel, input logic is_mask, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 2'(sel); wr_mask = is_mask; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_en(input logic [3:0] v);
    @(negedge clk);
    en_wr = 1'b1; en_data = v;
    @(negedge clk);
    en_wr = 1'b0;
  endtask

  task automatic get_reg(input int sel, input logic is_mask, output logic [31:0] d);
    @(negedge clk);
    rd_sel = 2'(sel); rd_mask = is_mask;
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic present(input logic [31:0] w, output logic acc, output logic vld, output logic bsy);
    @(negedge clk);
    id_valid = 1'b1; id_word = w;
    @(negedge clk);
    id_valid = 1'b0;
    acc = dec_accept; vld = dec_valid; bsy = busy;
  endtask

  function automatic logic expect_acc(input logic [31:0] w, input logic [3:0] en);
    logic any = 1'b0;
    if (en == 4'b0) return 1'b1;
    for (int i = 0; i < 4; i++)
      if (en[i] && ((w & m_ref[i]) == (f_ref[i] & m_ref[i]))) any = 1'b1;
    return any;
  endfunction

  function automatic logic [31:0] pat(input int k);
    case (k)
      0: return 32'h2460_0000;  1: return 32'h2460_0001;
      2: return 32'h2470_0000;  3: return 32'h2480_0000;
      4: return 32'h1357_9BDE;  5: return 32'h1357_9BDF;
      6: return 32'h1357_9ADE;  7: return 32'h0008_0000;
      8: return 32'h0000_0001;  9: return 32'hFFFF_FFFF;
      10: return 32'h0000_0000;
      default: return 32'h5555_AAAA;
    endcase
  endfunction

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #2000000;
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    logic [31:0] d;
    logic acc, vld, bsy;
    rst = 1'b1; id_valid = 1'b0; id_word = '0; wr_en = 1'b0; wr_sel = '0;
    wr_mask = 1'b0; wr_data = '0; en_wr = 1'b0; en_data = '0; rd_sel = '0; rd_mask = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 en_state", 32'(en_state), 32'h0);
    chk("R1 dec_valid", 32'(dec_valid), 32'h0);
    chk("R1 busy", 32'(busy), 32'h0);
    chk("R1 dec_accept", 32'(dec_accept), 32'h0);
    for (int i = 0; i < 4; i++) begin
      get_reg(i, 1'b1, d); chk("R1 mask zero", d, 32'h0);
      get_reg(i, 1'b0, d); chk("R1 ident zero", d, 32'h0);
    end
    // program filters; R8 filter 2 selects extension flag at bit 19
    m_ref[0] = 32'hFFE0_0000; f_ref[0] = 32'h2460_0000;
    m_ref[1] = 32'hFFFF_FFFE; f_ref[1] = 32'h1357_9BDE;
    m_ref[2] = 32'h0008_0000; f_ref[2] = 32'h0008_0000;
    m_ref[3] = 32'h0000_0001; f_ref[3] = 32'h0000_0001;
    for (int i = 0; i < 4; i++) begin
      put_reg(i, 1'b1, m_ref[i]);
      put_reg(i, 1'b0, f_ref[i]);
    end
    for (int i = 0; i < 4; i++) begin
      get_reg(i, 1'b1, d); chk("R9 mask readback", d, m_ref[i]);
      get_reg(i, 1'b0, d); chk("R9 ident readback", d, f_ref[i]);
    end
    // R2 R3 R4 sweep over every enable word and identifier pattern
    for (int e = 0; e < 16; e++) begin
      set_en(4'(e));
      chk("R9 en_state", 32'(en_state), 32'(e));
      for (int k = 0; k < 12; k++) begin
        present(pat(k), acc, vld, bsy);
        if (e == 0) chk("R4 fallback accept", 32'(acc), 32'h1);
        else chk("R2 R3 masked match", 32'(acc), 32'(expect_acc(pat(k), 4'(e))));
        if (k == 0) begin
          chk("R5 dec_valid", 32'(vld), 32'h1);
          chk("R5 busy", 32'(bsy), 32'h1);
          @(negedge clk);
          chk("R5 one-cycle strobe", 32'(dec_valid), 32'h0);
        end
      end
    end
    // R8 extension flag at bit 19
    set_en(4'b0100);
    present(32'h2460_0000, acc, vld, bsy); chk("R8 standard frame rejected", 32'(acc), 32'h0);
    present(32'h2468_0000, acc, vld, bsy); chk("R8 extended frame accepted", 32'(acc), 32'h1);
    // R6 write to an enabled filter is dropped
    set_en(4'b0001);
    put_reg(0, 1'b1, 32'hDEAD_BEEF);
    put_reg(0, 1'b0, 32'h0BAD_F00D);
    get_reg(0, 1'b1, d); chk("R6 enabled mask kept", d, m_ref[0]);
    get_reg(0, 1'b0, d); chk("R6 enabled ident kept", d, f_ref[0]);
    // a disabled filter in the same cycle stays writable
    put_reg(3, 1'b0, 32'h0000_0000); f_ref[3] = 32'h0;
    get_reg(3, 1'b0, d); chk("R6 disabled ident written", d, 32'h0);
    // R7 write during busy is dropped
    set_en(4'b0000);
    @(negedge clk);
    id_valid = 1'b1; id_word = 32'h0;
    @(negedge clk);
    id_valid = 1'b0;
    chk("R7 busy high", 32'(busy), 32'h1);
    wr_en = 1'b1; wr_sel = 2'd1; wr_mask = 1'b1; wr_data = 32'h1111_2222;
    @(negedge clk);
    wr_en = 1'b0;
    get_reg(1, 1'b1, d); chk("R7 busy write dropped", d, m_ref[1]);
    // R1 reset again clears state
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R1 en after reset", 32'(en_state), 32'h0);
    get_reg(1, 1'b1, d); chk("R1 mask after reset", d, 32'h0);
    summary();
  end
endmodule